// File: doc/BRIEF.md
# Serviced Watchdog with Selectable Clock Divider

This block guards a processor against runaway software. A 16-bit up-counter advances once per divider tick. The divider takes the system clock and divides it by a small or a large ratio, chosen by a select input. If software lets the counter run past its all-ones value, the block raises a reset request for a fixed number of clocks. The request is meant to drive the chip-wide reset. Software avoids this by servicing the block at regular intervals. A service is a two-step sequence: first an arm strobe, then a confirm strobe while the arm is still pending. It places an 8-bit reload value in the counter's upper byte and zeroes the lower byte and the divider. The period after a service is therefore set by the reload value and the divide ratio alone.

The watchdog starts enabled after every reset. A disable strobe switches it off, and it stays off until the next reset. A cause flag is set whenever the watchdog fires. The block's own re-initialisation does not clear the flag, so after restart software can tell a watchdog-induced reset from a pin reset. The flag clears on an external reset or on an explicit clear strobe.

Top module: `wdog_top`

## Requirements
- R1: After the external reset is released, `wd_reset_req` and `wd_cause` are 0 and the watchdog is enabled: it counts and can expire without any write.
- R2: With `div_slow`=0 (divide by 2), the first clock edge on which the request is high comes exactly 2*(256-reload)*256 edges after the edge that sampled the confirm strobe of a valid service.
- R3: With `div_slow`=1 (divide by 128), that distance is 128*(256-reload)*256 edges.
- R4: A valid service loads the reload register into counter bits [15:8], clears bits [7:0] and clears the divider. A second service restarts the full period from its own confirm edge.
- R5: A confirm strobe with no pending arm has no effect on the time to expiry.
- R6: An arm stays pending for 256 clocks. A confirm sampled 1 to 256 edges after the arm edge completes a service. A confirm sampled 257 edges after it is ignored.
- R7: On expiry, `wd_reset_req` is high for exactly 4 consecutive clocks.
- R8: `wd_cause` goes to 1 on the expiry edge. It stays 1 through the watchdog's own re-initialisation. It returns to 0 only on `cause_clr_wr` or the external reset.
- R9: When the request pulse ends, the block restarts enabled. A later reload write and service give the timing of R2.
- R10: After `disable_wr`, no request is ever raised, even after services, until the external reset.
- R11: Writing the reload register changes nothing in the running period. The new value takes effect only at the next service.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_ext_n | input | 1 | External reset, active low, asynchronous |
| div_slow | input | 1 | Divider select: 0 divides by 2, 1 divides by 128 |
| reload_wr | input | 1 | Write strobe for the reload register |
| reload_val | input | 8 | Value written into the reload register |
| arm_wr | input | 1 | First step of a service |
| confirm_wr | input | 1 | Second step of a service |
| disable_wr | input | 1 | Switches the watchdog off until the next reset |
| cause_clr_wr | input | 1 | Clears the watchdog cause flag |
| wd_reset_req | output | 1 | Reset request pulse |
| wd_cause | output | 1 | Set when the last reset came from the watchdog |

## Verification
The properties assume that all strobes are synchronous to `clk` and that `div_slow` does not change within a service period. The stimulus changes every input only on the falling edge. It raises each strobe for one clock and sets the divider select before the service that starts a measured period. Random rounds pick the reload value from the top of its range with the fast divider, so every period fits the run. The slow divider is covered by one directed period with the largest reload value.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic {
        DIV_FAST = 1'b0,
        DIV_SLOW = 1'b1
    } div_sel_e;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
    import wdog_pkg::*;
#(
    parameter int FAST_DIV = 2,
    parameter int SLOW_DIV = 128
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run_i,
    input  logic     clr_i,
    input  div_sel_e sel_i,
    output logic     tick_o
);
    localparam int PW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
    localparam logic [PW-1:0] LIM_FAST = PW'(FAST_DIV - 1);
    localparam logic [PW-1:0] LIM_SLOW = PW'(SLOW_DIV - 1);

    logic [PW-1:0] div_d, div_q;
    logic [PW-1:0] lim;

    always_comb begin
        lim    = (sel_i == DIV_SLOW) ? LIM_SLOW : LIM_FAST;
        tick_o = run_i && (div_q >= lim);
        div_d  = div_q;
        if (clr_i || !run_i) begin
            div_d = '0;
        end else if (tick_o) begin
            div_d = '0;
        end else begin
            div_d = div_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end
endmodule

// File: rtl/wdog_service.sv
module wdog_service #(
    parameter int ARM_WINDOW = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic confirm_i,
    input  logic flush_i,
    output logic fire_o
);
    localparam int AW = (ARM_WINDOW > 2) ? $clog2(ARM_WINDOW) : 1;
    localparam logic [AW-1:0] AGE_LAST = AW'(ARM_WINDOW - 1);

    typedef struct packed {
        logic          armed;
        logic [AW-1:0] age;
    } svc_state_t;

    svc_state_t sv_d, sv_q;

    always_comb begin
        sv_d   = sv_q;
        fire_o = 1'b0;
        if (sv_q.armed) begin
            if (confirm_i && !flush_i) begin
                fire_o   = 1'b1;
                sv_d.armed = 1'b0;
            end else if (sv_q.age == AGE_LAST) begin
                sv_d.armed = 1'b0;
            end else begin
                sv_d.age = sv_q.age + 1'b1;
            end
        end
        if (arm_i) begin
            sv_d.armed = 1'b1;
            sv_d.age   = '0;
        end
        if (flush_i) begin
            sv_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sv_q <= '0;
        end else begin
            sv_q <= sv_d;
        end
    end
endmodule

// File: rtl/wdog_rstgen.sv
module wdog_rstgen #(
    parameter int PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = $clog2(PULSE_LEN + 1);
    localparam logic [CW-1:0] LEN = CW'(PULSE_LEN);

    logic [CW-1:0] left_d, left_q;

    always_comb begin
        busy_o = (left_q != '0);
        done_o = (left_q == CW'(1));
        left_d = left_q;
        if (start_i) begin
            left_d = LEN;
        end else if (busy_o) begin
            left_d = left_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else begin
            left_q <= left_d;
        end
    end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int REL_W      = 8,
    parameter int FAST_DIV   = 2,
    parameter int SLOW_DIV   = 128,
    parameter int ARM_WINDOW = 256,
    parameter int PULSE_LEN  = 4
) (
    input  logic             clk,
    input  logic             rst_ext_n,
    input  logic             div_slow,
    input  logic             reload_wr,
    input  logic [REL_W-1:0] reload_val,
    input  logic             arm_wr,
    input  logic             confirm_wr,
    input  logic             disable_wr,
    input  logic             cause_clr_wr,
    output logic             wd_reset_req,
    output logic             wd_cause
);
    localparam int LOW_W = CNT_W - REL_W;

    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] cnt;
        logic [REL_W-1:0] rel;
        logic             cause;
    } wd_state_t;

    localparam wd_state_t ST_RST = '{en: 1'b1, cnt: '0, rel: '0, cause: 1'b0};

    wd_state_t st_d, st_q;
    logic tick, run, svc_fire, busy, rst_done, expire, pre_clr;

    assign run     = st_q.en & ~busy;
    assign expire  = tick & (st_q.cnt == {CNT_W{1'b1}});
    assign pre_clr = svc_fire | rst_done;

    wdog_prescaler #(
        .FAST_DIV(FAST_DIV),
        .SLOW_DIV(SLOW_DIV)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_ext_n),
        .run_i (run),
        .clr_i (pre_clr),
        .sel_i (div_sel_e'(div_slow)),
        .tick_o(tick)
    );

    wdog_service #(
        .ARM_WINDOW(ARM_WINDOW)
    ) u_svc (
        .clk      (clk),
        .rst_n    (rst_ext_n),
        .arm_i    (arm_wr),
        .confirm_i(confirm_wr),
        .flush_i  (busy),
        .fire_o   (svc_fire)
    );

    wdog_rstgen #(
        .PULSE_LEN(PULSE_LEN)
    ) u_pulse (
        .clk    (clk),
        .rst_n  (rst_ext_n),
        .start_i(expire),
        .busy_o (busy),
        .done_o (rst_done)
    );

    always_comb begin
        st_d = st_q;
        if (reload_wr) begin
            st_d.rel = reload_val;
        end
        if (disable_wr) begin
            st_d.en = 1'b0;
        end
        if (svc_fire) begin
            st_d.cnt = {st_q.rel, {LOW_W{1'b0}}};
        end else if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (cause_clr_wr) begin
            st_d.cause = 1'b0;
        end
        if (expire) begin
            st_d.cause = 1'b1;
        end
        if (rst_done) begin
            st_d.en  = 1'b1;
            st_d.cnt = '0;
            st_d.rel = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_ext_n) begin
        if (!rst_ext_n) begin
            st_q <= ST_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign wd_reset_req = busy;
    assign wd_cause     = st_q.cause;
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
    parameter int CNT_W     = 16,
    parameter int REL_W     = 8,
    parameter int PULSE_LEN = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req,
    input logic             cause,
    input logic             en,
    input logic             fire,
    input logic [CNT_W-1:0] cnt,
    input logic [REL_W-1:0] rel
);
    logic [7:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else if (req) begin
            hi_q <= hi_q + 1'b1;
        end else begin
            hi_q <= '0;
        end
    end

    // R7
    pulse_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (int'(hi_q) < PULSE_LEN));

    // R7
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req) |-> (int'(hi_q) == PULSE_LEN));

    // R8
    cause_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cause) |-> $rose(req));

    // R10
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !$rose(req));

    // R4
    svc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (cnt[CNT_W-1:CNT_W-REL_W] == $past(rel)) && (cnt[CNT_W-REL_W-1:0] == '0));
endmodule

bind wdog_top wdog_chk #(
    .CNT_W    (CNT_W),
    .REL_W    (REL_W),
    .PULSE_LEN(PULSE_LEN)
) u_chk (
    .clk  (clk),
    .rst_n(rst_ext_n),
    .req  (wd_reset_req),
    .cause(wd_cause),
    .en   (st_q.en),
    .fire (svc_fire),
    .cnt  (st_q.cnt),
    .rel  (st_q.rel)
);

// File: tb/wdog_top_bench.sv
module wdog_top_bench;
    logic       clk = 1'b0;
    logic       rst_ext_n = 1'b0;
    logic       div_slow = 1'b0;
    logic       reload_wr = 1'b0;
    logic [7:0] reload_val = 8'h00;
    logic       arm_wr = 1'b0;
    logic       confirm_wr = 1'b0;
    logic       disable_wr = 1'b0;
    logic       cause_clr_wr = 1'b0;
    logic       wd_reset_req;
    logic       wd_cause;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    int ts, ts2, te, plen;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdog_top u_wdog_top (
        .clk         (clk),
        .rst_ext_n   (rst_ext_n),
        .div_slow    (div_slow),
        .reload_wr   (reload_wr),
        .reload_val  (reload_val),
        .arm_wr      (arm_wr),
        .confirm_wr  (confirm_wr),
        .disable_wr  (disable_wr),
        .cause_clr_wr(cause_clr_wr),
        .wd_reset_req(wd_reset_req),
        .wd_cause    (wd_cause)
    );

    function automatic int exp_period(input logic slow, input logic [7:0] rel);
        return (slow ? 128 : 2) * (256 - int'(rel)) * 256;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        reload_wr    = 1'b0;
        arm_wr       = 1'b0;
        confirm_wr   = 1'b0;
        disable_wr   = 1'b0;
        cause_clr_wr = 1'b0;
    endtask

    task automatic ext_reset();
        rst_ext_n = 1'b0;
        repeat (3) step();
        rst_ext_n = 1'b1;
        step();
    endtask

    task automatic write_reload(input logic [7:0] v);
        reload_val = v;
        reload_wr  = 1'b1;
        step();
    endtask

    task automatic service(output int t);
        arm_wr = 1'b1;
        step();
        confirm_wr = 1'b1;
        step();
        t = cyc;
    endtask

    task automatic wait_req(output int t);
        t = -1;
        for (int i = 0; i < 40000; i++) begin
            if (wd_reset_req) begin
                t = cyc;
                break;
            end
            step();
        end
    endtask

    task automatic pulse_len(output int n);
        n = 0;
        while (wd_reset_req && n < 100) begin
            n++;
            step();
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        ext_reset();
        // R1 reset state
        check(wd_reset_req == 1'b0, "R1 req after reset", int'(wd_reset_req), 0);
        check(wd_cause == 1'b0, "R1 cause after reset", int'(wd_cause), 0);

        // R2 fast divider, R7 pulse length, R8 cause set
        div_slow = 1'b0;
        write_reload(8'hFE);
        service(ts);
        wait_req(te);
        check(te - ts == exp_period(1'b0, 8'hFE), "R2 fast period", te - ts, exp_period(1'b0, 8'hFE));
        check(wd_cause == 1'b1, "R8 cause on expiry", int'(wd_cause), 1);
        pulse_len(plen);
        check(plen == 4, "R7 pulse length", plen, 4);
        check(wd_cause == 1'b1, "R8 cause kept after restart", int'(wd_cause), 1);
        cause_clr_wr = 1'b1;
        step();
        check(wd_cause == 1'b0, "R8 cause cleared by strobe", int'(wd_cause), 0);

        // R9 restarted block runs again after the pulse
        write_reload(8'hFD);
        service(ts);
        wait_req(te);
        check(te - ts == exp_period(1'b0, 8'hFD), "R9 period after restart", te - ts, exp_period(1'b0, 8'hFD));
        pulse_len(plen);

        // R11 reload write mid period has no effect
        write_reload(8'hFE);
        service(ts);
        repeat (100) step();
        write_reload(8'hF0);
        wait_req(te);
        check(te - ts == 1024, "R11 reload write deferred", te - ts, 1024);
        pulse_len(plen);

        // R5 confirm without arm ignored
        write_reload(8'hFE);
        service(ts);
        repeat (200) step();
        confirm_wr = 1'b1;
        step();
        wait_req(te);
        check(te - ts == 1024, "R5 lone confirm ignored", te - ts, 1024);
        pulse_len(plen);

        // R4 second service restarts the period
        write_reload(8'hFE);
        service(ts);
        repeat (500) step();
        service(ts2);
        wait_req(te);
        check(te - ts2 == 1024, "R4 reservice restarts", te - ts2, 1024);
        pulse_len(plen);

        // R6 confirm 257 edges after arm ignored
        write_reload(8'hFE);
        service(ts);
        arm_wr = 1'b1;
        step();
        repeat (256) step();
        confirm_wr = 1'b1;
        step();
        wait_req(te);
        check(te - ts == 1024, "R6 late confirm ignored", te - ts, 1024);
        pulse_len(plen);

        // R6 confirm 256 edges after arm accepted
        write_reload(8'hFE);
        service(ts);
        arm_wr = 1'b1;
        step();
        repeat (255) step();
        confirm_wr = 1'b1;
        step();
        ts2 = cyc;
        wait_req(te);
        check(te - ts2 == 1024, "R6 last window confirm", te - ts2, 1024);
        pulse_len(plen);

        // R3 slow divider
        div_slow = 1'b1;
        write_reload(8'hFF);
        service(ts);
        wait_req(te);
        check(te - ts == exp_period(1'b1, 8'hFF), "R3 slow period", te - ts, exp_period(1'b1, 8'hFF));
        pulse_len(plen);
        check(plen == 4, "R7 pulse length slow", plen, 4);
        div_slow = 1'b0;

        // R8 external reset clears the flag
        check(wd_cause == 1'b1, "R8 cause before pin reset", int'(wd_cause), 1);
        ext_reset();
        check(wd_cause == 1'b0, "R8 cause after pin reset", int'(wd_cause), 0);

        // R10 disable is sticky
        begin
            int seen = 0;
            write_reload(8'hFE);
            service(ts);
            disable_wr = 1'b1;
            step();
            for (int i = 0; i < 3000; i++) begin
                if (wd_reset_req) seen++;
                if (i == 1500) begin
                    arm_wr = 1'b1;
                end
                if (i == 1501) begin
                    confirm_wr = 1'b1;
                end
                step();
            end
            check(seen == 0, "R10 no request while off", seen, 0);
        end
        ext_reset();

        // R2 random reload values, R7 each pulse
        void'($urandom(32'h5EED_0017));
        for (int k = 0; k < 8; k++) begin
            logic [7:0] r;
            r = 8'($urandom_range(8'hFF, 8'hF8));
            write_reload(r);
            service(ts);
            repeat ($urandom_range(30, 0)) step();
            wait_req(te);
            check(te - ts == exp_period(1'b0, r), "R2 random period", te - ts, exp_period(1'b0, r));
            pulse_len(plen);
            check(plen == 4, "R7 random pulse", plen, 4);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule